// File: doc/BRIEF.md
# I2C EEPROM Transaction Classifier

This block watches a stream of I2C bus events that an upstream decoder has already recovered from SCL and SDA. Each event is presented for one cycle with `ev_valid`. The block follows each exchange with a serial EEPROM and decides what kind of access it was. It never drives the bus. It only observes the events.

When a transaction ends, the block emits one report. The report carries an operation code, the first word address touched, the number of data bytes, and a set of warning flags for protocol anomalies. It also carries the control code and chip-select fields of the last control byte that was seen.

The block keeps a word-address counter that mirrors the counter inside the EEPROM. This lets a read that carries no word address still report the address it returns data from. The counter holds its value across transactions and is loaded from a parameter at reset.

Top module: `eeprom_txn_classifier`

## Requirements
- R1: The block ignores every event until a start (kind 1) or a repeated start (kind 2) arrives. The next event must be an address-read (kind 4) or an address-write (kind 5). Any other event returns the block to idle and produces no report. The remaining kinds are: stop 3, data-read 6, data-write 7, ack 8, nack 9.
- R2: Each report carries two fields of the most recent address byte:
  - `txn_ctl_code`, which is bits 7..4 of that byte;
  - `txn_chip_sel`, which is bits CS_PINS..1 of that byte.
  In a random read, the most recent address byte is the second one (the address-read).
- R3: The word address is ADDR_BYTES bytes long, sent most significant byte first. With two bytes, the start address is {first, second}.
- R4: A write that stops after its word address and exactly one acknowledged data byte reports op 1 (byte write). A write that stops after its word address with no data byte produces no report and leaves the counter unchanged.
- R5: A write that stops after two or more acknowledged data bytes reports op 2 (page write), with the byte count.
- R6: A random read has this shape: a write of the word address, then a repeated start, an address-read, an ack, data-read bytes each followed by ack or nack, a final nack, and a stop. It reports op 4 for one data byte and op 5 for more than one.
- R7: A read with no word address reports op 3 (current-address read). Its shape is address-read, ack, one data-read, nack, stop. The start address is the counter value before the read.
- R8: The counter resets to ADDR_INIT. After each report, the counter equals the start address plus the byte count, modulo 2^(8*ADDR_BYTES). At all other times it holds its value.
- R9: A nack directly after the control byte reports op 0 with warning bit 0. A stop directly after the device ack, before any byte, reports op 0 with warning bit 1.
- R10: A stop that follows an acknowledged read byte in a random read sets warning bit 2. The op is then 4 for one byte, 5 for more than one, and 0 for none.
- R11: A repeated start where a stop was expected after the final nack reports the pending op with warning bit 3. The repeated start then begins a new transaction, which expects a control byte next.
- R12: Two warnings apply to page writes only, with PAGE_BYTES a power of two:
  - bit 4 is set when the byte count exceeds PAGE_BYTES;
  - bit 5 is set when address/PAGE_BYTES differs between the first address and the last address written.
- R13: A report is a single-cycle `txn_valid` pulse. It is registered on the clock edge that accepts the final event of the transaction. `txn_valid` is low during and after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Event strobe, one cycle per event |
| ev_kind | input | 4 | Event kind code |
| ev_byte | input | 8 | Byte carried by address and data events |
| txn_valid | output | 1 | One-cycle report strobe |
| txn_op | output | 3 | Operation code |
| txn_addr | output | 8*ADDR_BYTES | First word address of the transaction |
| txn_count | output | CNT_W | Number of data bytes (saturating) |
| txn_warn | output | 6 | Warning flags, bits 0..5 |
| txn_ctl_code | output | 4 | Control code of the latest address byte |
| txn_chip_sel | output | CS_PINS | Chip-select field of the latest address byte |

## Verification
If the sequencer is in the wrong state, the next terminating event either produces a report with the wrong op or produces no report at all. Either outcome is visible one cycle after the event that should have closed the transaction. A wrong counter stays hidden until the next current-address read, which then reports it as its start address. For this reason, the test places a current-address read after the silent and aborted cases. A wrong page computation shows only in bits 4 and 5 of a page-write report. The boundary cases tested are a page filled exactly to PAGE_BYTES, a page write of PAGE_BYTES+1 bytes, and a short write that crosses a page boundary.

// File: rtl/eecls_pkg.sv
package eecls_pkg;

  typedef enum logic [3:0] {
    EV_NONE    = 4'd0,
    EV_START   = 4'd1,
    EV_RSTART  = 4'd2,
    EV_STOP    = 4'd3,
    EV_ADDR_RD = 4'd4,
    EV_ADDR_WR = 4'd5,
    EV_DATA_RD = 4'd6,
    EV_DATA_WR = 4'd7,
    EV_ACK     = 4'd8,
    EV_NACK    = 4'd9
  } ev_kind_e;

  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_BYTE_WR = 3'd1,
    OP_PAGE_WR = 3'd2,
    OP_CUR_RD  = 3'd3,
    OP_RAND_RD = 3'd4,
    OP_SEQ_RD  = 3'd5
  } op_e;

  localparam int WARN_W    = 6;
  localparam int WB_NOACK  = 0;
  localparam int WB_ABORT  = 1;
  localparam int WB_ACKSTP = 2;
  localparam int WB_RSTART = 3;
  localparam int WB_OVER   = 4;
  localparam int WB_CROSS  = 5;

  typedef enum logic [3:0] {
    S_IDLE, S_CTRL, S_RCACK, S_RBYTE, S_RBACK,
    S_WCACK, S_WADDR, S_WAACK, S_WDATA, S_WDACK,
    S_R2CTRL, S_R2CACK, S_R2BYTE, S_R2BACK, S_LAST
  } st_e;

endpackage

// File: rtl/eecls_seq.sv
module eecls_seq
  import eecls_pkg::*;
#(
  parameter int ADDR_BYTES = 1
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     ev_valid,
  input  ev_kind_e ev_kind,
  input  logic     cnt_is0,
  input  logic     cnt_is1,
  output logic     rpt,
  output op_e      rpt_op,
  output logic [3:0] rpt_warn,
  output logic     wa_we,
  output logic     cnt_inc,
  output logic     cnt_clr,
  output logic     ctl_we
);

  localparam int IDX_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ADDR_BYTES - 1);

  st_e              state, state_n;
  op_e              pend, pend_n;
  logic [IDX_W-1:0] idx, idx_n;

  always_comb begin
    state_n  = state;
    pend_n   = pend;
    idx_n    = idx;
    rpt      = 1'b0;
    rpt_op   = OP_NONE;
    rpt_warn = '0;
    wa_we    = 1'b0;
    cnt_inc  = 1'b0;
    cnt_clr  = 1'b0;
    ctl_we   = 1'b0;
    if (ev_valid) begin
      state_n = S_IDLE;
      case (state)
        S_IDLE: begin
          if (ev_kind == EV_START || ev_kind == EV_RSTART) begin
            state_n = S_CTRL;
            cnt_clr = 1'b1;
          end
        end
        S_CTRL: begin
          if (ev_kind == EV_ADDR_RD) begin
            ctl_we = 1'b1; state_n = S_RCACK;
          end else if (ev_kind == EV_ADDR_WR) begin
            ctl_we = 1'b1; state_n = S_WCACK;
          end
        end
        S_RCACK: begin
          if (ev_kind == EV_ACK) state_n = S_RBYTE;
          else if (ev_kind == EV_NACK) begin
            rpt = 1'b1; rpt_warn[WB_NOACK] = 1'b1;
          end
        end
        S_RBYTE: begin
          if (ev_kind == EV_DATA_RD) begin
            cnt_inc = 1'b1; state_n = S_RBACK;
          end else if (ev_kind == EV_STOP) begin
            rpt = 1'b1; rpt_warn[WB_ABORT] = 1'b1;
          end
        end
        S_RBACK: begin
          if (ev_kind == EV_NACK) begin
            pend_n = OP_CUR_RD; state_n = S_LAST;
          end
        end
        S_WCACK: begin
          if (ev_kind == EV_ACK) begin
            idx_n = '0; state_n = S_WADDR;
          end else if (ev_kind == EV_NACK) begin
            rpt = 1'b1; rpt_warn[WB_NOACK] = 1'b1;
          end
        end
        S_WADDR: begin
          if (ev_kind == EV_DATA_WR) begin
            wa_we = 1'b1; state_n = S_WAACK;
          end else if (ev_kind == EV_STOP) begin
            rpt = 1'b1; rpt_warn[WB_ABORT] = 1'b1;
          end
        end
        S_WAACK: begin
          if (ev_kind == EV_ACK) begin
            if (idx == LAST_IDX) state_n = S_WDATA;
            else begin
              idx_n   = idx + 1'b1;
              state_n = S_WADDR;
            end
          end
        end
        S_WDATA: begin
          if (ev_kind == EV_DATA_WR) begin
            cnt_inc = 1'b1; state_n = S_WDACK;
          end else if (ev_kind == EV_STOP) begin
            rpt    = !cnt_is0;
            rpt_op = cnt_is1 ? OP_BYTE_WR : OP_PAGE_WR;
          end else if (ev_kind == EV_RSTART && cnt_is0) begin
            state_n = S_R2CTRL;
          end
        end
        S_WDACK:  if (ev_kind == EV_ACK) state_n = S_WDATA;
        S_R2CTRL: begin
          if (ev_kind == EV_ADDR_RD) begin
            ctl_we = 1'b1; state_n = S_R2CACK;
          end
        end
        S_R2CACK: if (ev_kind == EV_ACK) state_n = S_R2BYTE;
        S_R2BYTE: begin
          if (ev_kind == EV_DATA_RD) begin
            cnt_inc = 1'b1; state_n = S_R2BACK;
          end else if (ev_kind == EV_STOP) begin
            rpt = 1'b1;
            rpt_warn[WB_ACKSTP] = 1'b1;
            rpt_op = cnt_is0 ? OP_NONE : (cnt_is1 ? OP_RAND_RD : OP_SEQ_RD);
          end
        end
        S_R2BACK: begin
          if (ev_kind == EV_ACK) state_n = S_R2BYTE;
          else if (ev_kind == EV_NACK) begin
            pend_n  = cnt_is1 ? OP_RAND_RD : OP_SEQ_RD;
            state_n = S_LAST;
          end
        end
        S_LAST: begin
          if (ev_kind == EV_STOP) begin
            rpt = 1'b1; rpt_op = pend;
          end else if (ev_kind == EV_RSTART) begin
            rpt = 1'b1; rpt_op = pend;
            rpt_warn[WB_RSTART] = 1'b1;
            cnt_clr = 1'b1;
            state_n = S_CTRL;
          end
        end
        default: state_n = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      pend  <= OP_NONE;
      idx   <= '0;
    end else begin
      state <= state_n;
      pend  <= pend_n;
      idx   <= idx_n;
    end
  end

  // R13: a report is only ever raised by an accepted event
  a_r13_rpt_needs_event: assert property (@(posedge clk) disable iff (rst)
    rpt |-> ev_valid);

  // R1: the block leaves idle only through a start condition
  a_r1_idle_exit: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && !(ev_valid && (ev_kind == EV_START || ev_kind == EV_RSTART)))
      |=> state == S_IDLE);

endmodule

// File: rtl/eecls_track.sv
module eecls_track #(
  parameter int ADDR_BYTES = 1,
  parameter int CNT_W      = 8,
  parameter int PAGE_BYTES = 8,
  parameter logic [8*ADDR_BYTES-1:0] ADDR_INIT = '0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [7:0]              ev_byte,
  input  logic                    wa_we,
  input  logic                    cnt_inc,
  input  logic                    cnt_clr,
  input  logic                    rpt,
  output logic                    cnt_is0,
  output logic                    cnt_is1,
  output logic [8*ADDR_BYTES-1:0] start_addr,
  output logic [CNT_W-1:0]        byte_cnt,
  output logic                    pg_over,
  output logic                    pg_cross
);

  localparam int ADDR_W = 8 * ADDR_BYTES;
  localparam int PG_SH  = $clog2(PAGE_BYTES);
  localparam logic [CNT_W-1:0] PAGE_C = CNT_W'(PAGE_BYTES);

  logic [ADDR_W-1:0] wa, ctr, last_addr;
  logic              wa_ok;

  generate
    if (ADDR_BYTES == 1) begin : g_wa_one
      always_ff @(posedge clk) begin
        if (rst) wa <= '0;
        else if (wa_we) wa <= ev_byte;
      end
    end else begin : g_wa_multi
      always_ff @(posedge clk) begin
        if (rst) wa <= '0;
        else if (wa_we) wa <= {wa[ADDR_W-9:0], ev_byte};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ctr      <= ADDR_INIT;
      byte_cnt <= '0;
      wa_ok    <= 1'b0;
    end else begin
      if (rpt) ctr <= start_addr + ADDR_W'(byte_cnt);
      if (cnt_clr) begin
        byte_cnt <= '0;
        wa_ok    <= 1'b0;
      end else begin
        if (cnt_inc && byte_cnt != '1) byte_cnt <= byte_cnt + 1'b1;
        if (wa_we) wa_ok <= 1'b1;
      end
    end
  end

  always_comb begin
    start_addr = wa_ok ? wa : ctr;
    cnt_is0    = (byte_cnt == '0);
    cnt_is1    = (byte_cnt == CNT_W'(1));
    last_addr  = start_addr + ADDR_W'(byte_cnt) - 1'b1;
    pg_over    = byte_cnt > PAGE_C;
    pg_cross   = !cnt_is0 && ((start_addr >> PG_SH) != (last_addr >> PG_SH));
  end

  // R8: the counter moves only when a transaction is reported
  a_r8_ctr_hold: assert property (@(posedge clk) disable iff (rst)
    !rpt |=> $stable(ctr));

  // R8: a cleared byte count is zero on the following cycle
  a_r8_cnt_clear: assert property (@(posedge clk) disable iff (rst)
    cnt_clr |=> cnt_is0);

endmodule

// File: rtl/eeprom_txn_classifier.sv
module eeprom_txn_classifier
  import eecls_pkg::*;
#(
  parameter int ADDR_BYTES = 1,
  parameter int CS_PINS    = 3,
  parameter int PAGE_BYTES = 8,
  parameter int CNT_W      = 8,
  parameter logic [8*ADDR_BYTES-1:0] ADDR_INIT = '0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ev_valid,
  input  logic [3:0]              ev_kind,
  input  logic [7:0]              ev_byte,
  output logic                    txn_valid,
  output logic [2:0]              txn_op,
  output logic [8*ADDR_BYTES-1:0] txn_addr,
  output logic [CNT_W-1:0]        txn_count,
  output logic [5:0]              txn_warn,
  output logic [3:0]              txn_ctl_code,
  output logic [CS_PINS-1:0]      txn_chip_sel
);

  localparam int ADDR_W = 8 * ADDR_BYTES;

  logic              rpt, wa_we, cnt_inc, cnt_clr, ctl_we;
  logic              cnt_is0, cnt_is1, pg_over, pg_cross, is_page;
  op_e               rpt_op;
  logic [3:0]        rpt_warn;
  logic [ADDR_W-1:0] start_addr;
  logic [CNT_W-1:0]  byte_cnt;
  logic [3:0]        code_q;
  logic [CS_PINS-1:0] sel_q;

  eecls_seq #(.ADDR_BYTES(ADDR_BYTES)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .ev_valid (ev_valid),
    .ev_kind  (ev_kind_e'(ev_kind)),
    .cnt_is0  (cnt_is0),
    .cnt_is1  (cnt_is1),
    .rpt      (rpt),
    .rpt_op   (rpt_op),
    .rpt_warn (rpt_warn),
    .wa_we    (wa_we),
    .cnt_inc  (cnt_inc),
    .cnt_clr  (cnt_clr),
    .ctl_we   (ctl_we)
  );

  eecls_track #(
    .ADDR_BYTES (ADDR_BYTES),
    .CNT_W      (CNT_W),
    .PAGE_BYTES (PAGE_BYTES),
    .ADDR_INIT  (ADDR_INIT)
  ) u_track (
    .clk        (clk),
    .rst        (rst),
    .ev_byte    (ev_byte),
    .wa_we      (wa_we),
    .cnt_inc    (cnt_inc),
    .cnt_clr    (cnt_clr),
    .rpt        (rpt),
    .cnt_is0    (cnt_is0),
    .cnt_is1    (cnt_is1),
    .start_addr (start_addr),
    .byte_cnt   (byte_cnt),
    .pg_over    (pg_over),
    .pg_cross   (pg_cross)
  );

  assign is_page = (rpt_op == OP_PAGE_WR);

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      sel_q  <= '0;
    end else if (ctl_we) begin
      code_q <= ev_byte[7:4];
      sel_q  <= ev_byte[CS_PINS:1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      txn_valid    <= 1'b0;
      txn_op       <= OP_NONE;
      txn_addr     <= '0;
      txn_count    <= '0;
      txn_warn     <= '0;
      txn_ctl_code <= '0;
      txn_chip_sel <= '0;
    end else begin
      txn_valid <= rpt;
      if (rpt) begin
        txn_op       <= rpt_op;
        txn_addr     <= start_addr;
        txn_count    <= byte_cnt;
        txn_warn     <= {pg_cross & is_page, pg_over & is_page, rpt_warn};
        txn_ctl_code <= code_q;
        txn_chip_sel <= sel_q;
      end
    end
  end

  // R13: reports are isolated single-cycle pulses
  a_r13_single_pulse: assert property (@(posedge clk) disable iff (rst)
    txn_valid |=> !txn_valid);

  // R4: a byte write always carries exactly one data byte
  a_r4_byte_count: assert property (@(posedge clk) disable iff (rst)
    (txn_valid && txn_op == OP_BYTE_WR) |-> txn_count == CNT_W'(1));

  // R7: a current-address read carries exactly one data byte
  a_r7_cur_count: assert property (@(posedge clk) disable iff (rst)
    (txn_valid && txn_op == OP_CUR_RD) |-> txn_count == CNT_W'(1));

  // R12: page warnings never appear outside a page write
  a_r12_page_only: assert property (@(posedge clk) disable iff (rst)
    (txn_valid && txn_op != OP_PAGE_WR) |-> txn_warn[5:4] == 2'b00);

  // R9: an unclassified report always explains itself with a warning
  a_r9_none_warns: assert property (@(posedge clk) disable iff (rst)
    (txn_valid && txn_op == OP_NONE) |-> txn_warn[3:0] != 4'h0);

endmodule

// File: tb/test_eeprom_txn_classifier.sv
`timescale 1ns/1ps
module test_eeprom_txn_classifier;
  import eecls_pkg::*;

  typedef struct packed {
    ev_kind_e   k;
    logic [7:0] b;
    logic       rep;
    op_e        op;
    logic [7:0] a;
    logic [7:0] n;
    logic [5:0] w;
  } vec_t;

  function automatic vec_t ev(ev_kind_e k, logic [7:0] b);
    return '{k: k, b: b, rep: 1'b0, op: OP_NONE, a: 8'h00, n: 8'h00, w: 6'h00};
  endfunction

  function automatic vec_t rp(ev_kind_e k, op_e op, logic [7:0] a,
                              logic [7:0] n, logic [5:0] w);
    return '{k: k, b: 8'h00, rep: 1'b1, op: op, a: a, n: n, w: w};
  endfunction

  localparam int NV = 52;
  localparam vec_t VEC [NV] = '{
    // current-address read from reset counter (R7, R8)
    ev(EV_START,0), ev(EV_ADDR_RD,8'hA7), ev(EV_ACK,0), ev(EV_DATA_RD,8'h55),
    ev(EV_NACK,0), rp(EV_STOP, OP_CUR_RD, 8'h00, 8'd1, 6'h00),
    // byte write (R4)
    ev(EV_START,0), ev(EV_ADDR_WR,8'hA0), ev(EV_ACK,0), ev(EV_DATA_WR,8'h10),
    ev(EV_ACK,0), ev(EV_DATA_WR,8'h99), ev(EV_ACK,0),
    rp(EV_STOP, OP_BYTE_WR, 8'h10, 8'd1, 6'h00),
    // page write inside one page (R5)
    ev(EV_START,0), ev(EV_ADDR_WR,8'hA0), ev(EV_ACK,0), ev(EV_DATA_WR,8'h20),
    ev(EV_ACK,0), ev(EV_DATA_WR,8'h01), ev(EV_ACK,0), ev(EV_DATA_WR,8'h02),
    ev(EV_ACK,0), ev(EV_DATA_WR,8'h03), ev(EV_ACK,0),
    rp(EV_STOP, OP_PAGE_WR, 8'h20, 8'd3, 6'h00),
    // page write crossing 0x27/0x28 (R12)
    ev(EV_START,0), ev(EV_ADDR_WR,8'hA0), ev(EV_ACK,0), ev(EV_DATA_WR,8'h26),
    ev(EV_ACK,0), ev(EV_DATA_WR,8'h04), ev(EV_ACK,0), ev(EV_DATA_WR,8'h05),
    ev(EV_ACK,0), ev(EV_DATA_WR,8'h06), ev(EV_ACK,0),
    rp(EV_STOP, OP_PAGE_WR, 8'h26, 8'd3, 6'h20),
    // random read (R6)
    ev(EV_START,0), ev(EV_ADDR_WR,8'hA0), ev(EV_ACK,0), ev(EV_DATA_WR,8'h40),
    ev(EV_ACK,0), ev(EV_RSTART,0), ev(EV_ADDR_RD,8'hA1), ev(EV_ACK,0),
    ev(EV_DATA_RD,8'h77), ev(EV_NACK,0),
    rp(EV_STOP, OP_RAND_RD, 8'h40, 8'd1, 6'h00),
    // no device answer (R9)
    ev(EV_START,0), ev(EV_ADDR_WR,8'hA0),
    rp(EV_NACK, OP_NONE, 8'h41, 8'd0, 6'h01)
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ev_valid = 1'b0;
  ev_kind_e    ev_kind = EV_NONE;
  logic [7:0]  ev_byte = 8'h00;

  logic        n_valid, w_valid;
  logic [2:0]  n_op, w_op;
  logic [7:0]  n_addr, n_cnt, w_cnt;
  logic [15:0] w_addr;
  logic [5:0]  n_warn, w_warn;
  logic [3:0]  n_code, w_code;
  logic [2:0]  n_sel, w_sel;

  int nchk  = 0;
  int nfail = 0;

  always #2.5 clk = ~clk;

  eeprom_txn_classifier i_eeprom_txn_classifier (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_byte(ev_byte),
    .txn_valid(n_valid), .txn_op(n_op), .txn_addr(n_addr), .txn_count(n_cnt),
    .txn_warn(n_warn), .txn_ctl_code(n_code), .txn_chip_sel(n_sel)
  );

  eeprom_txn_classifier #(.ADDR_BYTES(2), .ADDR_INIT(16'h1234)) i_eeprom_txn_classifier_w2 (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_byte(ev_byte),
    .txn_valid(w_valid), .txn_op(w_op), .txn_addr(w_addr), .txn_count(w_cnt),
    .txn_warn(w_warn), .txn_ctl_code(w_code), .txn_chip_sel(w_sel)
  );

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    ev_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // drive one event for one cycle; outputs are sampled at the following negedge
  task automatic send(input ev_kind_e k, input logic [7:0] b);
    @(negedge clk);
    ev_valid = 1'b1;
    ev_kind  = k;
    ev_byte  = b;
    @(negedge clk);
    ev_valid = 1'b0;
    ev_kind  = EV_NONE;
  endtask

  task automatic chk_none(input string tag);
    nchk++;
    if (n_valid !== 1'b0) begin
      nfail++;
      $display("FAIL %s: txn_valid=%b expected 0", tag, n_valid);
    end
  endtask

  task automatic chk_rep(input string tag, input op_e op, input logic [7:0] a,
                         input logic [7:0] n, input logic [5:0] w);
    nchk++;
    if (!(n_valid === 1'b1 && n_op === op && n_addr === a && n_cnt === n && n_warn === w)) begin
      nfail++;
      $display("FAIL %s: got v=%b op=%0d addr=%h cnt=%0d warn=%h, expected v=1 op=%0d addr=%h cnt=%0d warn=%h",
               tag, n_valid, n_op, n_addr, n_cnt, n_warn, op, a, n, w);
    end
  endtask

  task automatic chk_wide(input string tag, input op_e op, input logic [15:0] a,
                          input logic [7:0] n, input logic [5:0] w);
    nchk++;
    if (!(w_valid === 1'b1 && w_op === op && w_addr === a && w_cnt === n && w_warn === w)) begin
      nfail++;
      $display("FAIL %s: got v=%b op=%0d addr=%h cnt=%0d warn=%h, expected v=1 op=%0d addr=%h cnt=%0d warn=%h",
               tag, w_valid, w_op, w_addr, w_cnt, w_warn, op, a, n, w);
    end
  endtask

  task automatic chk_ctl(input string tag, input logic [3:0] code, input logic [2:0] sel);
    nchk++;
    if (!(n_code === code && n_sel === sel)) begin
      nfail++;
      $display("FAIL %s: got code=%h sel=%b, expected code=%h sel=%b", tag, n_code, n_sel, code, sel);
    end
  endtask

  // intermediate event: no report may appear
  task automatic step(input ev_kind_e k, input logic [7:0] b);
    send(k, b);
    chk_none("R13 no report mid-transaction");
  endtask

  task automatic cur_read(input logic [7:0] ctl);
    step(EV_START, 0); step(EV_ADDR_RD, ctl); step(EV_ACK, 0);
    step(EV_DATA_RD, 8'h3C); step(EV_NACK, 0);
    send(EV_STOP, 0);
  endtask

  task automatic page_wr(input logic [7:0] a, input int n);
    step(EV_START, 0); step(EV_ADDR_WR, 8'hA0); step(EV_ACK, 0);
    step(EV_DATA_WR, a); step(EV_ACK, 0);
    for (int i = 0; i < n; i++) begin
      step(EV_DATA_WR, 8'(i)); step(EV_ACK, 0);
    end
    send(EV_STOP, 0);
  endtask

  function automatic string tag_of(op_e op);
    case (op)
      OP_CUR_RD:  return "R7 current read";
      OP_BYTE_WR: return "R4 byte write";
      OP_PAGE_WR: return "R5 page write";
      OP_RAND_RD: return "R6 random read";
      OP_SEQ_RD:  return "R6 sequential read";
      default:    return "R9 no answer";
    endcase
  endfunction

  initial begin
    #500000;
    nfail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    summary();
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    chk_none("R13 reset state");
    nchk++;
    if (w_valid !== 1'b0) begin
      nfail++;
      $display("FAIL R13 reset state wide: txn_valid=%b expected 0", w_valid);
    end

    // two-byte address instance: initial counter and high-first address
    cur_read(8'hA1);
    chk_wide("R8 wide init counter", OP_CUR_RD, 16'h1234, 8'd1, 6'h00);
    send(EV_START, 0); send(EV_ADDR_WR, 8'hA0); send(EV_ACK, 0);
    send(EV_DATA_WR, 8'h12); send(EV_ACK, 0); send(EV_DATA_WR, 8'h3F); send(EV_ACK, 0);
    send(EV_DATA_WR, 8'h01); send(EV_ACK, 0); send(EV_DATA_WR, 8'h02); send(EV_ACK, 0);
    send(EV_STOP, 0);
    chk_wide("R3 two-byte address, R12 cross", OP_PAGE_WR, 16'h123F, 8'd2, 6'h20);

    do_reset();

    for (int i = 0; i < NV; i++) begin
      send(VEC[i].k, VEC[i].b);
      if (VEC[i].rep) chk_rep(tag_of(VEC[i].op), VEC[i].op, VEC[i].a, VEC[i].n, VEC[i].w);
      else chk_none("R1/R13 table mid-transaction");
    end

    // R6 sequential random read of three bytes, counter then at 0x53
    step(EV_START, 0); step(EV_ADDR_WR, 8'hA0); step(EV_ACK, 0);
    step(EV_DATA_WR, 8'h50); step(EV_ACK, 0); step(EV_RSTART, 0);
    step(EV_ADDR_RD, 8'hA1); step(EV_ACK, 0);
    step(EV_DATA_RD, 0); step(EV_ACK, 0); step(EV_DATA_RD, 0); step(EV_ACK, 0);
    step(EV_DATA_RD, 0); step(EV_NACK, 0);
    send(EV_STOP, 0);
    chk_rep("R6 sequential read", OP_SEQ_RD, 8'h50, 8'd3, 6'h00);

    // R7, R8, R2: counter continues, control fields from 0xA7
    cur_read(8'hA7);
    chk_rep("R7 current read after sequential", OP_CUR_RD, 8'h53, 8'd1, 6'h00);
    chk_ctl("R2 control fields", 4'hA, 3'b011);

    // R9 master abort on write and read paths
    step(EV_START, 0); step(EV_ADDR_WR, 8'hA0); step(EV_ACK, 0);
    send(EV_STOP, 0);
    chk_rep("R9 abort write path", OP_NONE, 8'h54, 8'd0, 6'h02);
    step(EV_START, 0); step(EV_ADDR_RD, 8'hA1); step(EV_ACK, 0);
    send(EV_STOP, 0);
    chk_rep("R9 abort read path", OP_NONE, 8'h54, 8'd0, 6'h02);

    // R10 stop after acked byte; R2 second control byte 0xAD
    step(EV_START, 0); step(EV_ADDR_WR, 8'hA0); step(EV_ACK, 0);
    step(EV_DATA_WR, 8'h60); step(EV_ACK, 0); step(EV_RSTART, 0);
    step(EV_ADDR_RD, 8'hAD); step(EV_ACK, 0); step(EV_DATA_RD, 0); step(EV_ACK, 0);
    send(EV_STOP, 0);
    chk_rep("R10 stop after ack", OP_RAND_RD, 8'h60, 8'd1, 6'h04);
    chk_ctl("R2 latest control byte", 4'hA, 3'b110);

    // R11 repeated start instead of stop, then the new transaction proceeds
    step(EV_START, 0); step(EV_ADDR_RD, 8'hA1); step(EV_ACK, 0);
    step(EV_DATA_RD, 0); step(EV_NACK, 0);
    send(EV_RSTART, 0);
    chk_rep("R11 restart instead of stop", OP_CUR_RD, 8'h61, 8'd1, 6'h08);
    step(EV_ADDR_RD, 8'hA1); step(EV_ACK, 0); step(EV_DATA_RD, 0); step(EV_NACK, 0);
    send(EV_STOP, 0);
    chk_rep("R11 transaction after restart", OP_CUR_RD, 8'h62, 8'd1, 6'h00);

    // R1 a data event after start returns to idle without touching the counter
    step(EV_START, 0); step(EV_DATA_WR, 8'h00); step(EV_ACK, 0); step(EV_STOP, 0);
    cur_read(8'hA1);
    chk_rep("R1 bad event ignored", OP_CUR_RD, 8'h63, 8'd1, 6'h00);

    // R4 write with address only: silent, counter unchanged
    page_wr(8'h70, 0);
    chk_none("R4 address-only write silent");
    cur_read(8'hA1);
    chk_rep("R4 counter unchanged by address-only write", OP_CUR_RD, 8'h64, 8'd1, 6'h00);

    // R12 overflow by one byte (also crosses), then exact full page
    page_wr(8'h30, 9);
    chk_rep("R12 page overflow", OP_PAGE_WR, 8'h30, 8'd9, 6'h30);
    page_wr(8'h40, 8);
    chk_rep("R12 exact page no warning", OP_PAGE_WR, 8'h40, 8'd8, 6'h00);
    cur_read(8'hA1);
    chk_rep("R8 counter after page write", OP_CUR_RD, 8'h48, 8'd1, 6'h00);

    summary();
    $finish;
  end

endmodule